// File: doc/BRIEF.md
# Sequential-Run Address Bus Codec

This block sits on both ends of a low-power address bus and keeps the bus wires quiet while the address stream climbs in fixed steps. On the sending side, each valid address is compared with the previous address plus a fixed stride. A matching address is not placed on the wires. The address lines keep their old value, and the receiver computes the address itself from its own copy of the last address it rebuilt.

A parameter selects one of two bus forms. The flagged form adds one increment line, which is high for every address that is not transmitted. The flagless form has no extra line. In that form the receiver reads a sequential step from an address bus that has not changed, and reads a break in the run from any new value on the wires. A non-sequential address can equal the value already on the wires. The sender then transmits a substitute, the expected next address, which a true break can never carry. The receiver maps that substitute back to the old bus value.

Both ends share one clock and reset. The sender registers the bus, and the receiver registers the rebuilt address, so the rebuilt stream trails the input by two cycles.

Top module: `seq_addr_bus_codec`

## Requirements
- R1: While reset is asserted and after it is released, `bus_addr`, `bus_inc`, `bus_vld`, `out_valid` and `out_addr` are all zero until the first valid input.
- R2: The first valid address after reset is placed on `bus_addr` in full with `bus_inc` low, even if it equals zero plus the stride.
- R3: In flagged mode (FLAGGED=1), an address equal to the previous address plus STRIDE (modulo 2^AW) drives `bus_inc` high one cycle later and leaves `bus_addr` unchanged.
- R4: In flagged mode, a non-sequential address appears on `bus_addr` one cycle later with `bus_inc` low.
- R5: In flagless mode (FLAGGED=0), a sequential address leaves `bus_addr` unchanged. A non-sequential address that differs from the current `bus_addr` value is placed on `bus_addr` one cycle later.
- R6: In flagless mode, a non-sequential address that equals the current `bus_addr` value is sent as the substitute previous address plus STRIDE.
- R7: Every valid input address reappears on `out_addr` with `out_valid` high exactly two cycles after it was accepted, in order, in both modes and across wrap-around at 2^AW.
- R8: While `in_valid` is low, `bus_addr`, `bus_inc` and `out_addr` keep their values, and `bus_vld` and `out_valid` fall.
- R9: In flagless mode, `bus_inc` stays low at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock of sender and receiver |
| rst_n | input | 1 | Active-low synchronous reset for both ends |
| in_valid | input | 1 | An address is offered this cycle |
| in_addr | input | AW | Address to carry across the bus |
| bus_vld | output | 1 | Bus transfer strobe |
| bus_addr | output | AW | Address lines, frozen during sequential runs |
| bus_inc | output | 1 | Increment line (flagged mode only, else zero) |
| out_valid | output | 1 | Rebuilt address is valid |
| out_addr | output | AW | Rebuilt address at the receiver |

## Verification
Both bus forms get the same stream, so their bus waveforms can be told apart while their rebuilt outputs must agree. The stream starts with an address that looks sequential to the reset state, which separates a correct first-transfer rule from a naive comparison. Runs broken by idle gaps show that a run survives the gap and that the wires stay put. A jump back to the frozen value drives the flagless substitute path, and a run that crosses the top of the address space checks modular stride arithmetic at both ends.

// File: rtl/seq_addr_bus_codec.sv
module seq_addr_bus_codec #(
  parameter int AW      = 16,
  parameter int STRIDE  = 1,
  parameter bit FLAGGED = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [AW-1:0] in_addr,
  output logic          bus_vld,
  output logic [AW-1:0] bus_addr,
  output logic          bus_inc,
  output logic          out_valid,
  output logic [AW-1:0] out_addr
);
  localparam logic [AW-1:0] STEP = AW'(STRIDE);

  logic [AW-1:0] enc_prev, dec_prev, dec_bus, enc_next, dec_addr;
  logic          enc_primed, dec_primed;

  wire enc_seq = enc_primed && (in_addr == enc_prev + STEP);
  wire enc_clash = !FLAGGED && enc_primed && (in_addr == bus_addr);
  wire [AW-1:0] dec_pred = dec_prev + STEP;
  wire dec_hold = FLAGGED ? bus_inc : (bus_addr == dec_bus);

  always_comb begin
    if (enc_seq)        enc_next = bus_addr;
    else if (enc_clash) enc_next = enc_prev + STEP;
    else                enc_next = in_addr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_vld    <= 1'b0;
      bus_addr   <= '0;
      bus_inc    <= 1'b0;
      enc_prev   <= '0;
      enc_primed <= 1'b0;
    end else begin
      bus_vld <= in_valid;
      if (in_valid) begin
        bus_addr   <= enc_next;
        bus_inc    <= FLAGGED && enc_seq;
        enc_prev   <= in_addr;
        enc_primed <= 1'b1;
      end
    end
  end

  always_comb begin
    if (!dec_primed)                      dec_addr = bus_addr;
    else if (dec_hold)                    dec_addr = dec_pred;
    else if (!FLAGGED && bus_addr == dec_pred) dec_addr = dec_bus;
    else                                  dec_addr = bus_addr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_addr   <= '0;
      dec_prev   <= '0;
      dec_bus    <= '0;
      dec_primed <= 1'b0;
    end else begin
      out_valid <= bus_vld;
      if (bus_vld) begin
        out_addr   <= dec_addr;
        dec_prev   <= dec_addr;
        dec_bus    <= bus_addr;
        dec_primed <= 1'b1;
      end
    end
  end

  // R2
  first_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enc_primed && in_valid) |=> (bus_addr == $past(in_addr) && !bus_inc));

  // R7
  rebuild_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_addr == $past(in_addr, 2)));

  // R8
  idle_bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(bus_addr) && $stable(bus_inc) && !bus_vld));

  // R8
  idle_out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_vld |=> ($stable(out_addr) && !out_valid));

  generate
    if (FLAGGED) begin : g_flag
      // R3
      frozen_on_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_inc) |-> $stable(bus_addr));
    end else begin : g_noflag
      // R9
      no_inc_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_inc);
      // R6
      clash_differs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && enc_clash && !enc_seq) |=> !$stable(bus_addr));
    end
  endgenerate
endmodule

// File: tb/test_seq_addr_bus_codec.sv
module test_seq_addr_bus_codec;
  localparam int AW = 16;
  localparam logic [AW-1:0] STEP = 16'd1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [AW-1:0] in_addr = '0;

  logic          f_bvld, f_binc, f_ovld, n_bvld, n_binc, n_ovld;
  logic [AW-1:0] f_baddr, f_oaddr, n_baddr, n_oaddr;

  always #10 clk = ~clk;

  seq_addr_bus_codec #(.AW(AW), .STRIDE(1), .FLAGGED(1'b1)) i_seq_addr_bus_codec (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
    .bus_vld(f_bvld), .bus_addr(f_baddr), .bus_inc(f_binc),
    .out_valid(f_ovld), .out_addr(f_oaddr));

  seq_addr_bus_codec #(.AW(AW), .STRIDE(1), .FLAGGED(1'b0)) i_seq_addr_bus_codec_nf (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
    .bus_vld(n_bvld), .bus_addr(n_baddr), .bus_inc(n_binc),
    .out_valid(n_ovld), .out_addr(n_oaddr));

  int checks = 0;
  int fails = 0;
  logic [AW-1:0] q_f[$];
  logic [AW-1:0] q_n[$];

  logic          primed = 1'b0;
  logic [AW-1:0] prev = '0;
  logic [AW-1:0] exp_fbus = '0;
  logic [AW-1:0] exp_nbus = '0;
  logic          exp_finc = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [AW-1:0] a, input string req);
    bit seq;
    seq = primed && (a == prev + STEP);
    in_valid = 1'b1;
    in_addr  = a;
    q_f.push_back(a);
    q_n.push_back(a);
    if (!primed) begin
      exp_fbus = a; exp_finc = 1'b0; exp_nbus = a;
    end else begin
      exp_finc = seq;
      if (!seq) exp_fbus = a;
      if (!seq) exp_nbus = (a == exp_nbus) ? prev + STEP : a;
    end
    primed = 1'b1;
    prev = a;
    @(posedge clk);
    @(negedge clk);
    chk(f_baddr == exp_fbus, {req, " flagged bus_addr"}, f_baddr, exp_fbus);
    chk(f_binc == exp_finc, {req, " flagged bus_inc"}, AW'(f_binc), AW'(exp_finc));
    chk(n_baddr == exp_nbus, {req, " flagless bus_addr"}, n_baddr, exp_nbus);
    chk(n_binc == 1'b0, "R9 flagless bus_inc", AW'(n_binc), '0);
    chk(f_bvld && n_bvld, {req, " bus_vld"}, AW'(f_bvld), 1);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    in_addr  = 16'hDEAD;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk(f_baddr == exp_fbus && f_binc == exp_finc, "R8 flagged bus held", f_baddr, exp_fbus);
      chk(n_baddr == exp_nbus, "R8 flagless bus held", n_baddr, exp_nbus);
      chk(!f_bvld && !n_bvld, "R8 bus_vld low", AW'(f_bvld), '0);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && f_ovld) begin
      if (q_f.size() == 0) chk(1'b0, "R7 flagged unexpected output", f_oaddr, '0);
      else begin
        logic [AW-1:0] e;
        e = q_f.pop_front();
        chk(f_oaddr == e, "R7 flagged rebuilt address", f_oaddr, e);
      end
    end
    if (rst_n && n_ovld) begin
      if (q_n.size() == 0) chk(1'b0, "R7 flagless unexpected output", n_oaddr, '0);
      else begin
        logic [AW-1:0] e;
        e = q_n.pop_front();
        chk(n_oaddr == e, "R7 flagless rebuilt address", n_oaddr, e);
      end
    end
  end

  initial begin
    #2000000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(f_baddr == 0 && !f_binc && !f_bvld && !f_ovld && f_oaddr == 0, "R1 flagged reset", f_baddr, '0);
    chk(n_baddr == 0 && !n_binc && !n_bvld && !n_ovld && n_oaddr == 0, "R1 flagless reset", n_baddr, '0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(f_baddr == 0 && !f_bvld && !f_ovld, "R1 after release", f_baddr, '0);

    send(16'd1, "R2");
    send(16'd2, "R3 R5");
    send(16'd3, "R3 R5");
    idle(2);
    send(16'd4, "R3 R5");
    send(16'd100, "R4 R5");
    send(16'd101, "R3 R5");
    send(16'd100, "R6");
    send(16'd103, "R4 R5");
    send(16'd5, "R4 R5");
    send(16'd6, "R3 R5");
    send(16'd5, "R6");
    send(16'hFFFE, "R4 R5");
    send(16'hFFFF, "R3 R5");
    send(16'h0000, "R3 R7 wrap");
    send(16'h0000, "R4 R5");
    idle(1);
    send(16'h0001, "R3 R5");
    idle(3);
    chk(f_oaddr == 16'h0001 && n_oaddr == 16'h0001, "R8 out held", f_oaddr, 16'h0001);
    chk(!f_ovld && !n_ovld, "R8 out_valid low", AW'(f_ovld), '0);
    chk(q_f.size() == 0 && q_n.size() == 0, "R7 all addresses delivered", AW'(q_f.size()), '0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule